// File: doc/BRIEF.md
# Packet-Counting SPI Master

This block is a register-mapped SPI master for one serial device. Software pushes outgoing data into a 64-byte transmit queue and pops incoming data from a 64-byte receive queue. The access width is either a single byte or a full 32-bit word, and in word access an optional lane swap in each direction repacks the word, so that the byte order in memory can match the order on the wire. The serial side runs SPI mode 0: the clock idles low, data is shifted most significant bit first, and each clock half-period lasts a fixed number of system cycles.

A packet counter limits reception to a programmed number of units. A unit is one byte or one 32-bit word, chosen by the channel width field. Once the limit is reached, later received bytes are discarded. The serial clock keeps running for as long as transmit data remains. Each direction has its own enable bit. A soft reset empties both queues and stops the shifter, and leaves every configuration register as it was. One register bit sets the chip-select level directly.

Top module: `spi_pkt_master`

## Requirements
- R1: After reset, cs_n is 1 and sclk is 0. STATUS reads 0x00000001: both levels are zero and the done flag is set. MODE reads 0 and CSCTL reads 1.
- R2: The serial clock idles low. Each half-period lasts CLK_DIV system cycles. MOSI presents the byte MSB first and holds steady while sclk is high. MISO is sampled on each rising sclk edge.
- R3: The transmit queue holds 64 bytes. A TXDATA write (address 6) that needs more free space than the queue has is dropped whole. STATUS[14:6] reports the transmit level.
- R4: An RXDATA read (address 7) while the queue holds fewer bytes than the access width returns 0 and removes nothing. STATUS[23:15] reports the receive level.
- R5: MODE[3:2] selects the access width: 0 means byte, 2 means 32-bit word. A byte write queues bits [7:0], and a byte read returns the byte zero-extended. A word write queues 4 bytes, bits [7:0] of the (swapped) word first. A word read places the first received byte in bits [7:0].
- R6: SWAP (address 2) has bit0 tx enable, bit1 tx byte swap, bit2 tx halfword swap, bit3 rx enable, bit4 rx byte swap, bit5 rx halfword swap. When a direction is enabled, its byte swap exchanges the bytes inside each halfword, and then its halfword swap exchanges the two halfwords. Swapping applies only to word access.
- R7: PKTCNT (address 3) has a count in bits [15:0] and an enable in bit 16. A unit is 4 bytes when MODE[1:0] is 2 and 1 byte otherwise. With the counter enabled, received bytes beyond count times unit are not queued, while sclk keeps toggling for as long as transmit data remains. Writing PKTCNT restarts the count.
- R8: CTRL (address 0) bit0 lets the shifter start bytes, and bit1 lets received bytes enter the receive queue.
- R9: While CTRL bit2 (soft reset) is set, both queues are empty and the shifter is idle. MODE, SWAP, PKTCNT and CSCTL keep their values.
- R10: CSCTL (address 4) bit0 drives cs_n: 1 makes it inactive (high) and 0 makes it active (low).
- R11: STATUS bit0 is 1 exactly when the transmit queue is empty and no byte is being shifted or delivered.
- R12: When a host RXDATA read and a received-byte push land in the same cycle, both take effect. The read sees the queue as it was before the push.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on RXDATA) |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the strobe cycle |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
A host read of RXDATA and the shifter's delivery of a finished byte can commit on the same clock edge. The bench provokes this by counting eight rising sclk edges after it queues a byte. It then places the read strobe exactly CLK_DIV+1 cycles later, which is the edge on which the delivered byte enters the queue. The collision is run once with two older bytes already in the queue and once with the queue empty. The bench judges each run by the value returned, which is either the oldest byte or zero, and by the level afterwards, which is the previous level plus one minus the bytes popped.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;

    localparam logic [2:0] ADDR_CTRL   = 3'd0;
    localparam logic [2:0] ADDR_MODE   = 3'd1;
    localparam logic [2:0] ADDR_SWAP   = 3'd2;
    localparam logic [2:0] ADDR_PKTCNT = 3'd3;
    localparam logic [2:0] ADDR_CSCTL  = 3'd4;
    localparam logic [2:0] ADDR_STATUS = 3'd5;
    localparam logic [2:0] ADDR_TXDATA = 3'd6;
    localparam logic [2:0] ADDR_RXDATA = 3'd7;

    localparam logic [1:0] WIDTH_BYTE = 2'd0;
    localparam logic [1:0] WIDTH_WORD = 2'd2;

    typedef struct packed {
        logic rx_half;
        logic rx_byte;
        logic rx_en;
        logic tx_half;
        logic tx_byte;
        logic tx_en;
    } swap_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    // Byte swap inside halfwords first, then halfword exchange.
    function automatic logic [31:0] lane_swap(input logic [31:0] w,
                                              input logic en,
                                              input logic bsw,
                                              input logic hsw);
        logic [31:0] r;
        r = w;
        if (en && bsw) r = {r[23:16], r[31:24], r[7:0], r[15:8]};
        if (en && hsw) r = {r[15:0], r[31:16]};
        return r;
    endfunction

endpackage

// File: rtl/spi_pkt_fifo.sv
module spi_pkt_fifo #(
    parameter int DEPTH  = 64,
    parameter int PUSH_W = 4,
    parameter int POP_W  = 1,
    localparam int AW    = $clog2(DEPTH),
    localparam int LW    = AW + 1,
    localparam int PNW   = $clog2(PUSH_W + 1),
    localparam int QNW   = $clog2(POP_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic [PNW-1:0]       push_n,
    input  logic [PUSH_W*8-1:0]  push_data,
    input  logic [QNW-1:0]       pop_n,
    output logic [POP_W*8-1:0]   pop_data,
    output logic [LW-1:0]        level,
    output logic                 push_ok,
    output logic                 pop_ok
);

    // DEPTH must be a power of two: pointers wrap by truncation.
    typedef struct packed {
        logic [DEPTH*8-1:0] mem;
        logic [AW-1:0]      wr;
        logic [AW-1:0]      rd;
        logic [LW-1:0]      lvl;
    } fifo_st_t;

    fifo_st_t      q, d;
    logic [LW-1:0] free_sp;
    logic [AW-1:0] idx;

    always_comb begin
        d        = q;
        idx      = '0;
        free_sp  = LW'(DEPTH) - q.lvl;
        push_ok  = (push_n != '0) && (free_sp >= LW'(push_n)) && !clr;
        pop_ok   = (pop_n != '0) && (q.lvl >= LW'(pop_n)) && !clr;
        pop_data = '0;
        for (int i = 0; i < POP_W; i++) begin
            idx = q.rd + AW'(i);
            if (pop_ok && (QNW'(i) < pop_n)) begin
                pop_data[i*8 +: 8] = q.mem[int'(idx)*8 +: 8];
            end
        end
        if (clr) begin
            d.wr  = '0;
            d.rd  = '0;
            d.lvl = '0;
        end else begin
            for (int i = 0; i < PUSH_W; i++) begin
                idx = q.wr + AW'(i);
                if (push_ok && (PNW'(i) < push_n)) begin
                    d.mem[int'(idx)*8 +: 8] = push_data[i*8 +: 8];
                end
            end
            if (push_ok) d.wr = q.wr + AW'(push_n);
            if (pop_ok)  d.rd = q.rd + AW'(pop_n);
            d.lvl = q.lvl + (push_ok ? LW'(push_n) : '0) - (pop_ok ? LW'(pop_n) : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign level = q.lvl;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    p_drop_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != '0 && !push_ok && pop_n == '0 && !clr) |=> $stable(level));

    p_pop_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_ok && push_n == '0) |=> (level == $past(level) - LW'($past(pop_n))));

endmodule

// File: rtl/spi_pkt_shifter.sv
module spi_pkt_shifter
    import spi_pkt_pkg::*;
#(
    parameter int CLK_DIV = 2,
    localparam int DW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       go,
    input  logic       tx_avail,
    input  logic [7:0] tx_byte,
    output logic       tx_take,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       rx_valid,
    output logic [7:0] rx_byte,
    output logic       busy
);

    typedef struct packed {
        phase_e        phase;
        logic [DW-1:0] div;
        logic [2:0]    bitn;
        logic [7:0]    tsh;
        logic [7:0]    rsh;
        logic          sclk;
        logic          rx_valid;
    } shf_st_t;

    shf_st_t q, d;
    logic    half_end;

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        tx_take    = 1'b0;
        half_end   = (q.div == DW'(CLK_DIV - 1));
        if (clr) begin
            d = '0;
        end else begin
            case (q.phase)
                PH_IDLE: begin
                    if (go && tx_avail) begin
                        tx_take = 1'b1;
                        d.tsh   = tx_byte;
                        d.bitn  = 3'd0;
                        d.div   = '0;
                        d.sclk  = 1'b0;
                        d.phase = PH_LOW;
                    end
                end
                PH_LOW: begin
                    if (half_end) begin
                        d.div   = '0;
                        d.sclk  = 1'b1;
                        d.rsh   = {q.rsh[6:0], miso};
                        d.phase = PH_HIGH;
                    end else begin
                        d.div = q.div + DW'(1);
                    end
                end
                PH_HIGH: begin
                    if (half_end) begin
                        d.div  = '0;
                        d.sclk = 1'b0;
                        if (q.bitn == 3'd7) begin
                            d.phase    = PH_IDLE;
                            d.rx_valid = 1'b1;
                        end else begin
                            d.bitn  = q.bitn + 3'd1;
                            d.tsh   = {q.tsh[6:0], 1'b0};
                            d.phase = PH_LOW;
                        end
                    end else begin
                        d.div = q.div + DW'(1);
                    end
                end
                default: d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sclk     = q.sclk;
    assign mosi     = q.tsh[7];
    assign rx_valid = q.rx_valid;
    assign rx_byte  = q.rsh;
    assign busy     = (q.phase != PH_IDLE) || q.rx_valid;

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    p_take_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_take |=> !tx_take);

endmodule

// File: rtl/spi_pkt_master.sv
module spi_pkt_master
    import spi_pkt_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int CLK_DIV    = 2,
    localparam int LW        = $clog2(FIFO_DEPTH) + 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        cs_n
);

    typedef struct packed {
        logic        tx_on;
        logic        rx_on;
        logic        srst;
        logic [1:0]  chw;
        logic [1:0]  busw;
        swap_cfg_t   swap;
        logic        pkt_en;
        logic [15:0] pkt_cnt;
        logic        cs_inact;
        logic [17:0] rx_taken;
    } top_st_t;

    top_st_t q, d;

    logic          word_bus, unit_word, room, tx_done;
    logic [17:0]   limit;
    logic [2:0]    tx_push_n, rx_pop_n;
    logic [31:0]   tx_push_data, rx_pop_data;
    logic          rx_push_n;
    logic [7:0]    tx_pop_data, sh_rx_byte;
    logic [LW-1:0] tx_lvl, rx_lvl;
    logic          tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic          sh_take, sh_rx_valid, sh_busy;

    spi_pkt_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(4), .POP_W(1)) u_txq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (q.srst),
        .push_n   (tx_push_n),
        .push_data(tx_push_data),
        .pop_n    (sh_take),
        .pop_data (tx_pop_data),
        .level    (tx_lvl),
        .push_ok  (tx_push_ok),
        .pop_ok   (tx_pop_ok)
    );

    spi_pkt_fifo #(.DEPTH(FIFO_DEPTH), .PUSH_W(1), .POP_W(4)) u_rxq (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (q.srst),
        .push_n   (rx_push_n),
        .push_data(sh_rx_byte),
        .pop_n    (rx_pop_n),
        .pop_data (rx_pop_data),
        .level    (rx_lvl),
        .push_ok  (rx_push_ok),
        .pop_ok   (rx_pop_ok)
    );

    spi_pkt_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (q.srst),
        .go      (q.tx_on),
        .tx_avail(tx_lvl != '0),
        .tx_byte (tx_pop_data),
        .tx_take (sh_take),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_valid(sh_rx_valid),
        .rx_byte (sh_rx_byte),
        .busy    (sh_busy)
    );

    always_comb begin
        d         = q;
        word_bus  = (q.busw == WIDTH_WORD);
        unit_word = (q.chw == WIDTH_WORD);
        limit     = unit_word ? {q.pkt_cnt, 2'b00} : {2'b00, q.pkt_cnt};
        room      = !q.pkt_en || (q.rx_taken < limit);
        tx_done   = (tx_lvl == '0) && !sh_busy;

        tx_push_n    = 3'd0;
        tx_push_data = '0;
        if (reg_wr && reg_addr == ADDR_TXDATA) begin
            tx_push_n    = word_bus ? 3'd4 : 3'd1;
            tx_push_data = word_bus
                ? lane_swap(reg_wdata, q.swap.tx_en, q.swap.tx_byte, q.swap.tx_half)
                : {24'h0, reg_wdata[7:0]};
        end
        rx_pop_n  = (reg_rd && reg_addr == ADDR_RXDATA) ? (word_bus ? 3'd4 : 3'd1) : 3'd0;
        rx_push_n = sh_rx_valid && q.rx_on && room && !q.srst;

        // Packet progress counts every accepted received byte.
        if (q.srst) begin
            d.rx_taken = '0;
        end else if (sh_rx_valid && q.rx_on && q.pkt_en && room) begin
            d.rx_taken = q.rx_taken + 18'd1;
        end

        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: begin
                    d.tx_on = reg_wdata[0];
                    d.rx_on = reg_wdata[1];
                    d.srst  = reg_wdata[2];
                end
                ADDR_MODE: begin
                    d.chw  = reg_wdata[1:0];
                    d.busw = reg_wdata[3:2];
                end
                ADDR_SWAP:  d.swap = reg_wdata[5:0];
                ADDR_PKTCNT: begin
                    d.pkt_cnt  = reg_wdata[15:0];
                    d.pkt_en   = reg_wdata[16];
                    d.rx_taken = '0;
                end
                ADDR_CSCTL: d.cs_inact = reg_wdata[0];
                default: ;
            endcase
        end

        case (reg_addr)
            ADDR_CTRL:   reg_rdata = {29'h0, q.srst, q.rx_on, q.tx_on};
            ADDR_MODE:   reg_rdata = {28'h0, q.busw, q.chw};
            ADDR_SWAP:   reg_rdata = {26'h0, q.swap};
            ADDR_PKTCNT: reg_rdata = {15'h0, q.pkt_en, q.pkt_cnt};
            ADDR_CSCTL:  reg_rdata = {31'h0, q.cs_inact};
            ADDR_STATUS: reg_rdata = {8'h0, 9'(rx_lvl), 9'(tx_lvl), 5'h0, tx_done};
            ADDR_RXDATA: reg_rdata = word_bus
                ? lane_swap(rx_pop_data, q.swap.rx_en, q.swap.rx_byte, q.swap.rx_half)
                : {24'h0, rx_pop_data[7:0]};
            default:     reg_rdata = 32'h0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.cs_inact <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n = q.cs_inact;

    p_cs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_CSCTL) |=> (cs_n == $past(reg_wdata[0])));

    p_pkt_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pkt_en && q.rx_taken >= limit && rx_pop_n == 3'd0 && !q.srst)
            |=> $stable(rx_lvl));

    p_srst_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> (tx_lvl == '0 && rx_lvl == '0));

    p_srst_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        q.srst |=> !sclk);

endmodule

// File: tb/spi_pkt_master_test.sv
`timescale 1ns/100ps
module spi_pkt_master_test;

    localparam int  DIV = 2;
    localparam real TCK = 5.0;
    localparam logic [2:0] A_CTRL = 3'd0, A_MODE = 3'd1, A_SWAP = 3'd2, A_PKT = 3'd3;
    localparam logic [2:0] A_CS = 3'd4, A_STAT = 3'd5, A_TX = 3'd6, A_RX = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, miso, cs_n;

    always #2.5 clk = ~clk;

    spi_pkt_master #(.FIFO_DEPTH(64), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    assign miso = mosi;

    // Wire monitor: collects MOSI bytes MSB first on rising sclk.
    logic [7:0] wire_log [256];
    logic [7:0] mon_sh = 8'h0;
    int         mon_bits = 0;
    int         mon_total = 0;
    always @(posedge sclk) begin
        mon_sh = {mon_sh[6:0], mosi};
        mon_bits++;
        if (mon_bits == 8) begin
            wire_log[mon_total % 256] = mon_sh;
            mon_total++;
            mon_bits = 0;
        end
    end

    int checks = 0;
    int errors = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        int n;
        n = 0;
        do begin
            rd_reg(A_STAT, s);
            n++;
        end while (!s[0] && n < 4000);
        repeat (3) @(negedge clk);
    endtask

    function automatic logic [31:0] model_swap(input logic [31:0] w, input logic en,
                                               input logic b, input logic h);
        logic [31:0] r;
        int sel;
        sel = ((en && b) ? 1 : 0) ^ ((en && h) ? 2 : 0);
        for (int k = 0; k < 4; k++) r[8*k +: 8] = w[8*(k ^ sel) +: 8];
        return r;
    endfunction

    initial begin
        repeat (1000000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, s, w, t, exp_rx;
        int st;
        realtime t0, t1, t2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 cs_n", {31'h0, cs_n}, 32'h1);
        chk("R1 sclk", {31'h0, sclk}, 32'h0);
        rd_reg(A_STAT, s); chk("R1 status", s, 32'h1);
        rd_reg(A_MODE, v); chk("R1 mode", v, 32'h0);
        rd_reg(A_CS, v);   chk("R1 csctl", v, 32'h1);

        // R10: chip select follows register bit0
        wr_reg(A_CS, 32'h0);
        chk("R10 cs active", {31'h0, cs_n}, 32'h0);
        wr_reg(A_CS, 32'h1);
        chk("R10 cs inactive", {31'h0, cs_n}, 32'h1);
        wr_reg(A_CS, 32'h0);

        // R3: fill the transmit queue with shifting disabled
        for (int i = 0; i < 65; i++) wr_reg(A_TX, 32'(i));
        rd_reg(A_STAT, s); chk("R3 tx level full", 32'(s[14:6]), 32'd64);
        chk("R3 no sclk while off", 32'(mon_total), 32'd0);
        wr_reg(A_MODE, 32'h8);
        wr_reg(A_TX, 32'h11223344);
        rd_reg(A_STAT, s); chk("R3 word write dropped", 32'(s[14:6]), 32'd64);

        // R9: soft reset empties queues, configuration kept
        wr_reg(A_MODE, 32'hA);
        wr_reg(A_SWAP, 32'h2D);
        wr_reg(A_PKT, 32'h1_0005);
        wr_reg(A_CTRL, 32'h4);
        rd_reg(A_STAT, s); chk("R9 levels cleared", s, 32'h1);
        wr_reg(A_CTRL, 32'h0);
        rd_reg(A_MODE, v); chk("R9 mode kept", v, 32'hA);
        rd_reg(A_SWAP, v); chk("R9 swap kept", v, 32'h2D);
        rd_reg(A_PKT, v);  chk("R9 pktcnt kept", v, 32'h1_0005);
        chk("R9 cs kept", {31'h0, cs_n}, 32'h0);
        wr_reg(A_PKT, 32'h0);

        // R4: short reads return zero
        rd_reg(A_RX, v); chk("R4 empty word read", v, 32'h0);
        wr_reg(A_MODE, 32'h0);
        rd_reg(A_RX, v); chk("R4 empty byte read", v, 32'h0);

        // R2: clock timing
        wr_reg(A_CTRL, 32'h3);
        wr_reg(A_TX, 32'hFF);
        @(posedge sclk); t0 = $realtime;
        @(negedge sclk); t1 = $realtime;
        @(posedge sclk); t2 = $realtime;
        chk("R2 high half", 32'(int'((t1 - t0) / TCK)), 32'(DIV));
        chk("R2 period", 32'(int'((t2 - t0) / TCK)), 32'(2 * DIV));
        wait_done();
        rd_reg(A_RX, v); chk("R2 loop byte", v, 32'hFF);

        // R11: done flag drops while data is pending
        wr_reg(A_TX, 32'h81);
        rd_reg(A_STAT, s); chk("R11 busy", {31'h0, s[0]}, 32'h0);
        wait_done();
        rd_reg(A_STAT, s); chk("R11 done", s, 32'h1 | (32'd1 << 15));
        rd_reg(A_RX, v);

        // R5 R2: byte sweep, swap bits set on odd values have no effect
        for (int b = 0; b < 256; b++) begin
            wr_reg(A_SWAP, (b % 2) ? 32'h3F : 32'h0);
            st = mon_total;
            wr_reg(A_TX, 32'hABCDEF00 | 32'(b));
            wait_done();
            chk("R2 wire byte MSB first", {24'h0, wire_log[st % 256]}, 32'(b));
            rd_reg(A_RX, v);
            chk("R5 byte read back", v, 32'(b));
        end

        // R6 R5: all swap settings in word access
        wr_reg(A_MODE, 32'h8);
        for (int c = 0; c < 64; c++) begin
            wr_reg(A_SWAP, 32'(c));
            w = 32'h4C3B2A19 + 32'(c * 32'h01010101);
            t = model_swap(w, c[0], c[1], c[2]);
            exp_rx = model_swap(t, c[3], c[4], c[5]);
            st = mon_total;
            wr_reg(A_TX, w);
            wait_done();
            for (int k = 0; k < 4; k++)
                chk("R5 wire order", {24'h0, wire_log[(st + k) % 256]}, {24'h0, t[8*k +: 8]});
            rd_reg(A_RX, v);
            chk("R6 swapped word", v, exp_rx);
        end
        wr_reg(A_SWAP, 32'h0);

        // R12: host read and byte delivery in the same cycle
        wr_reg(A_MODE, 32'h0);
        wr_reg(A_TX, 32'h5A);
        wr_reg(A_TX, 32'hA5);
        wait_done();
        wr_reg(A_TX, 32'h3C);
        repeat (8) @(posedge sclk);
        repeat (DIV) @(negedge clk);
        rd_reg(A_RX, v); chk("R12 collide read oldest", v, 32'h5A);
        repeat (3) @(negedge clk);
        rd_reg(A_STAT, s); chk("R12 level after collide", 32'(s[23:15]), 32'd2);
        rd_reg(A_RX, v); chk("R12 second byte", v, 32'hA5);
        rd_reg(A_RX, v); chk("R12 delivered byte", v, 32'h3C);
        wr_reg(A_TX, 32'hC3);
        repeat (8) @(posedge sclk);
        repeat (DIV) @(negedge clk);
        rd_reg(A_RX, v); chk("R12 collide on empty", v, 32'h0);
        repeat (3) @(negedge clk);
        rd_reg(A_STAT, s); chk("R12 level after empty collide", 32'(s[23:15]), 32'd1);
        rd_reg(A_RX, v); chk("R12 kept byte", v, 32'hC3);

        // R7: byte units, count 3, send 5
        wr_reg(A_PKT, 32'h1_0003);
        st = mon_total;
        for (int i = 0; i < 5; i++) wr_reg(A_TX, 32'h60 + 32'(i));
        wait_done();
        rd_reg(A_STAT, s); chk("R7 byte limit level", 32'(s[23:15]), 32'd3);
        chk("R7 clock ran for all", 32'(mon_total - st), 32'd5);
        for (int i = 0; i < 3; i++) begin
            rd_reg(A_RX, v); chk("R7 kept bytes", v, 32'h60 + 32'(i));
        end
        // R7: word units, count 1, send 2 words, then restart
        wr_reg(A_MODE, 32'hA);
        wr_reg(A_PKT, 32'h1_0001);
        st = mon_total;
        wr_reg(A_TX, 32'h01020304);
        wr_reg(A_TX, 32'h05060708);
        wait_done();
        rd_reg(A_STAT, s); chk("R7 word limit level", 32'(s[23:15]), 32'd4);
        chk("R7 clock ran 8 bytes", 32'(mon_total - st), 32'd8);
        rd_reg(A_RX, v); chk("R7 first word", v, 32'h01020304);
        wr_reg(A_PKT, 32'h1_0001);
        wr_reg(A_TX, 32'h0A0B0C0D);
        wait_done();
        rd_reg(A_STAT, s); chk("R7 restart level", 32'(s[23:15]), 32'd4);
        rd_reg(A_RX, v); chk("R7 restart word", v, 32'h0A0B0C0D);
        wr_reg(A_PKT, 32'h0);
        wr_reg(A_MODE, 32'h0);

        // R8: direction enables
        wr_reg(A_CTRL, 32'h2);
        st = mon_total;
        wr_reg(A_TX, 32'h77);
        repeat (100) @(negedge clk);
        rd_reg(A_STAT, s); chk("R8 tx held", 32'(s[14:6]), 32'd1);
        chk("R8 no clock", 32'(mon_total - st), 32'd0);
        wr_reg(A_CTRL, 32'h1);
        wait_done();
        chk("R8 sent", {24'h0, wire_log[st % 256]}, 32'h77);
        rd_reg(A_STAT, s); chk("R8 rx gated", 32'(s[23:15]), 32'd0);
        wr_reg(A_CTRL, 32'h3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule